// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Appender

This block sits in a MAC transmit path between the frame source and the line encoder. Frame bytes arrive one per beat on a valid/ready stream with start and end markers. The stream covers the destination address, source address, type/length, payload and any padding. Each accepted byte passes through unchanged, with no added latency. In the same cycle the byte is folded into a CRC-32 register at one full byte per clock.

When the final data byte has been accepted, the block emits the four-byte frame check sequence on the same output stream and moves the end marker onto the last of those bytes. While the check bytes are going out, the input is stalled. A bypass input is sampled with the start marker of each frame. When it is set, that frame passes through untouched and nothing is appended, so software can supply its own check field. Preamble and delimiter insertion, minimum-length padding and gap timing belong to other blocks.

Top module: `eth_fcs_append`

## Requirements
- R1: While no check bytes are being emitted, every accepted input byte appears on the output in the same cycle with the same value. The start marker appears on the first byte of a frame only.
- R2: The appended value is computed over all bytes of the frame. The CRC register starts at 0xFFFFFFFF. Each byte is bit-reversed and XORed into bits 31:24. Eight left shifts follow, and each shift XORs in 0x04C11DB7 when the bit leaving bit 31 was 1. The final register is complemented and then bit-reversed as a 32-bit word. The ASCII bytes "123456789" yield 0xCBF43926.
- R3: The four check bytes follow the last data byte directly, least significant byte first (0xCBF43926 goes out as 26, 39, F4, CB). The end marker is set on the fourth check byte only.
- R4: When appending is enabled, the last data byte leaves with its end marker cleared.
- R5: While check bytes are pending, in_ready_o is low and input beats are ignored.
- R6: If in_bypass_i is high on the start beat, the frame is forwarded unchanged with its end marker on its own last byte and no check bytes.
- R7: The CRC register is preset at every start beat, so earlier frames (bypassed or not) do not affect the result.
- R8: While out_ready_i is low during check emission, out_valid_o, out_data_o and out_eof_o hold their values.
- R9: After reset, with no input valid, out_valid_o is low and in_ready_o follows out_ready_i.
- R10: A frame of one byte (start and end markers on the same beat) gets a correct four-byte check field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block accepts the input byte |
| in_data_i | input | 8 | Input frame byte |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last data byte of a frame |
| in_bypass_i | input | 1 | Skip appending for this frame, sampled with in_sof_i |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | First byte of an output frame |
| out_eof_o | output | 1 | Last byte of an output frame |

## Verification
The bench compares the check field against a reflected-form CRC model in the bench and against the fixed value for "123456789". A design with a wrong bit order, a missing complement or a swapped byte order gives different bytes there. Frames of one byte, bypassed frames placed before appended ones, and random output stalls are all run. Across these, a stale register preset, an end marker left on the data byte, a byte leaking in during the check phase, or a check byte that changes while stalled each cause a byte or marker mismatch. While check bytes are pending, the bench keeps offering a junk start beat, so a block that does not stall its input is caught.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
  localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
  localparam int unsigned FCS_CNT_W = $clog2(FCS_BYTES);

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_FCS  = 1'b1
  } phase_e;
endpackage

// File: rtl/crc32_byte_step.sv
// One unrolled byte of MSB-first CRC division, input byte reflected first.
module crc32_byte_step #(
  parameter int unsigned CW = 32,
  parameter int unsigned DW = 8,
  parameter logic [CW-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  logic [DW-1:0] data_rev;
  logic [CW-1:0] stage [DW+1];

  for (genvar b = 0; b < DW; b++) begin : g_rev
    assign data_rev[b] = data_i[DW-1-b];
  end

  assign stage[0] = crc_i ^ {data_rev, {(CW-DW){1'b0}}};

  for (genvar k = 0; k < DW; k++) begin : g_shift
    assign stage[k+1] = stage[k][CW-1] ? ((stage[k] << 1) ^ POLY) : (stage[k] << 1);
  end

  assign crc_o = stage[DW];
endmodule

// File: rtl/crc32_finalize.sv
// Complement then reflect the whole register.
module crc32_finalize #(
  parameter int unsigned CW = 32
) (
  input  logic [CW-1:0] crc_i,
  output logic [CW-1:0] fcs_o
);
  logic [CW-1:0] inv;
  assign inv = ~crc_i;

  for (genvar b = 0; b < CW; b++) begin : g_rev
    assign fcs_o[b] = inv[CW-1-b];
  end
endmodule

// File: rtl/fcs_serializer.sv
// Holds the check word and shifts it out low byte first.
module fcs_serializer
  import eth_fcs_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned DW = BYTE_W,
  localparam int unsigned NB = CW / DW,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] word_i,
  input  logic          adv_i,
  output logic          busy_o,
  output logic [DW-1:0] byte_o,
  output logic          last_o
);
  phase_e        ph_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_DATA;
      idx_q  <= '0;
      word_q <= '0;
    end else if (load_i) begin
      ph_q   <= PH_FCS;
      idx_q  <= '0;
      word_q <= word_i;
    end else if (ph_q == PH_FCS && adv_i) begin
      word_q <= word_q >> DW;
      if (last_o) begin
        ph_q  <= PH_DATA;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = (ph_q == PH_FCS);
  assign byte_o = word_q[DW-1:0];
  assign last_o = (idx_q == IW'(NB-1));
endmodule

// File: rtl/eth_fcs_append.sv
module eth_fcs_append
  import eth_fcs_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned CHK_W  = CRC_W,
  parameter logic [CHK_W-1:0] POLY = CRC_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              in_bypass_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  logic [CHK_W-1:0]  crc_q, crc_base, crc_next, fcs_word;
  logic              byp_q, frame_byp, in_acc, fcs_load;
  logic              fcs_active, fcs_last;
  logic [DATA_W-1:0] fcs_byte;

  assign in_ready_o = out_ready_i && !fcs_active;
  assign in_acc     = in_valid_i && in_ready_o;
  assign frame_byp  = in_sof_i ? in_bypass_i : byp_q;
  assign crc_base   = in_sof_i ? {CHK_W{1'b1}} : crc_q;
  assign fcs_load   = in_acc && in_eof_i && !frame_byp;

  crc32_byte_step #(.CW(CHK_W), .DW(DATA_W), .POLY(POLY)) u_step (
    .crc_i  (crc_base),
    .data_i (in_data_i),
    .crc_o  (crc_next)
  );

  crc32_finalize #(.CW(CHK_W)) u_fin (
    .crc_i (crc_next),
    .fcs_o (fcs_word)
  );

  fcs_serializer #(.CW(CHK_W), .DW(DATA_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fcs_load),
    .word_i (fcs_word),
    .adv_i  (out_ready_i),
    .busy_o (fcs_active),
    .byte_o (fcs_byte),
    .last_o (fcs_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '1;
      byp_q <= 1'b0;
    end else if (in_acc) begin
      crc_q <= crc_next;
      if (in_sof_i) byp_q <= in_bypass_i;
    end
  end

  always_comb begin
    if (fcs_active) begin
      out_valid_o = 1'b1;
      out_data_o  = fcs_byte;
      out_sof_o   = 1'b0;
      out_eof_o   = fcs_last;
    end else begin
      out_valid_o = in_valid_i;
      out_data_o  = in_data_i;
      out_sof_o   = in_sof_i;
      out_eof_o   = in_eof_i && frame_byp;
    end
  end
endmodule

// File: rtl/eth_fcs_append_chk.sv
module eth_fcs_append_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_sof_i,
  input logic              in_eof_i,
  input logic              in_bypass_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_eof_o,
  input logic              fcs_active
);
  logic       c_byp_q, c_acc, c_byp;
  logic [2:0] c_cnt_q;

  assign c_acc = in_valid_i && in_ready_o;
  assign c_byp = in_sof_i ? in_bypass_i : c_byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_byp_q <= 1'b0;
      c_cnt_q <= '0;
    end else begin
      if (c_acc && in_sof_i) c_byp_q <= in_bypass_i;
      if (!fcs_active) c_cnt_q <= '0;
      else if (out_ready_i) c_cnt_q <= c_cnt_q + 1'b1;
    end
  end

  AST_FCS_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && in_eof_i && !c_byp) |=> fcs_active); // R4
  AST_BYPASS_NO_FCS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_acc && in_eof_i && c_byp) |=> !fcs_active); // R6
  AST_INPUT_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcs_active |-> !in_ready_o); // R5
  AST_FCS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcs_active |-> out_valid_o); // R3
  AST_FCS_FOUR_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_active && out_ready_i && out_eof_o) |-> (c_cnt_q == 3'd3)); // R3
  AST_FCS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcs_active && !out_ready_i) |=> (fcs_active && $stable(out_data_o) && $stable(out_eof_o))); // R8
endmodule

bind eth_fcs_append eth_fcs_append_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/eth_fcs_append_tb.sv
module eth_fcs_append_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // length, seed, bypass, stall
  localparam int VEC_LEN [NVEC] = '{1, 14, 7, 20, 1, 3, 33, 60};
  localparam int VEC_SEED[NVEC] = '{8'h00, 8'h11, 8'h5A, 8'hC3, 8'hFF, 8'h80, 8'h2D, 8'h71};
  localparam bit VEC_BYP [NVEC] = '{0, 0, 1, 0, 1, 0, 1, 0};
  localparam bit VEC_STL [NVEC] = '{0, 1, 0, 1, 1, 0, 1, 1};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_bypass = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic [7:0] out_data;

  int checks = 0, failures = 0;
  logic [7:0] frame [64];
  logic [7:0] expd [68];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_fcs_append u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .in_bypass_i(in_bypass),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reflected form of the same CRC, written independently.
  function automatic logic [31:0] model_crc(input int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      c ^= {24'h0, frame[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic run_frame(input int len, input bit byp, input bit stall, input bit fixed);
    int idx = 0, ob = 0, cyc = 0, exp_len;
    logic [31:0] f;
    logic [7:0] held = 0;
    bit hold_chk = 0;
    string dreq;
    f = fixed ? 32'hCBF4_3926 : model_crc(len);
    for (int i = 0; i < len; i++) expd[i] = frame[i];
    for (int i = 0; i < 4; i++) expd[len+i] = f[8*i +: 8];
    exp_len = byp ? len : len + 4;
    dreq = byp ? "R6" : "R1";
    while (ob < exp_len && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? lfsr[0] : 1'b1;
      in_valid = 1'b1;
      if (idx < len) begin
        in_data = frame[idx]; in_sof = (idx == 0); in_eof = (idx == len-1); in_bypass = byp;
      end else begin
        in_data = 8'hA5; in_sof = 1; in_eof = 1; in_bypass = 0;   // junk while check bytes pend
      end
      #1;
      if (hold_chk) check(out_data == held && out_valid, "R8", out_data, held);
      hold_chk = 0;
      if (idx >= len) check(in_ready == 0, "R5", in_ready, 0);
      if (out_valid && out_ready) begin
        check(out_data == expd[ob], (ob < len) ? dreq : "R2", out_data, expd[ob]);
        check(out_sof == (ob == 0), "R1", out_sof, ob == 0);
        check(out_eof == (ob == exp_len-1), (ob == len-1 && !byp) ? "R4" : "R3", out_eof, ob == exp_len-1);
        ob++;
      end else if (out_valid && ob >= len) begin
        hold_chk = 1; held = out_data;
      end
      if (in_valid && in_ready && idx < len) idx++;
    end
    check(ob == exp_len, "R3", ob, exp_len);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_bypass = 0; out_ready = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WATCHDOG", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R9", out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(out_valid == 0, "R9", out_valid, 0);
    check(in_ready == 1, "R9", in_ready, 1);
    out_ready = 0; #1;
    check(in_ready == 0, "R9", in_ready, 0);
    out_ready = 1;

    // table walk: one-byte frames (R10), bypass ahead of appended frames (R7)
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < VEC_LEN[v]; i++) frame[i] = 8'(VEC_SEED[v] + i * 37);
      run_frame(VEC_LEN[v], VEC_BYP[v], VEC_STL[v], 0);
    end

    // fixed known answer for "123456789": 26 39 F4 CB (R2, R3)
    for (int i = 0; i < 9; i++) frame[i] = 8'h31 + 8'(i);
    run_frame(9, 0, 0, 1);
    run_frame(9, 0, 1, 1);

    // one-byte frame right after a bypassed one (R10, R7)
    frame[0] = 8'hE7;
    run_frame(1, 1, 0, 0);
    run_frame(1, 0, 1, 0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule